// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls 32 general-purpose pins from a simple 32-bit register bus. The bus has a byte address, a write strobe, write data and read data. A write lands on the clock edge where the strobe is high. Read data is combinational from the current address.

Each pin has three state bits: a level bit, a drive-enable bit and an ownership bit. The ownership bit decides who drives the pin. When it is 0 the controller drives the pin from its own level and drive-enable bits. When it is 1 an alternate peripheral drives the pin through the `alt_out` and `alt_oe` ports. After reset every pin belongs to the peripheral.

The pins are grouped eight to a register word, and only the low byte of each word is used. The external pin levels pass through a two-stage synchronizer before software can read them.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every level bit and every drive-enable bit is 0 and every ownership bit is 1. So right after reset `pin_oe` equals `alt_oe`, `pin_out` equals `alt_out`, reads of 0x20 give 0x000000FF and reads of 0x10 give 0.
- R2: Pin n maps to bit (n mod 8) of a word at byte offset (n/8)*4 within its bank. The level bank is at 0x00, 0x04, 0x08 and 0x0C. The drive-enable bank is at 0x10–0x1C. The ownership bank is at 0x20–0x2C. A write stores bits 7:0 of the write data into the addressed word. Reading the drive-enable and ownership banks returns the stored bits.
- R3: When a pin's ownership bit is 0, `pin_oe` follows its drive-enable bit, where 1 means the pin is an output. `pin_out` follows its level bit.
- R4: When a pin's ownership bit is 1, `pin_out` and `pin_oe` follow `alt_out` and `alt_oe` for that pin, whatever its level and drive-enable bits hold.
- R5: A level bit written while the pin is an input is kept. When the drive-enable bit is later set, the pin drives that stored level in the cycle after the write.
- R6: Reading the level bank returns the stored level for output pins. For input pins it returns the synchronized pin input, and a change on `pin_in` becomes visible after the second rising clock edge.
- R7: Bits 31:8 of every read are 0, and bits 31:8 of the write data are ignored.
- R8: Unaligned addresses (address bits 1:0 not 00) and offsets of 0x30 and above read 0, and writes to them change no state.
- R9: A pin under controller ownership whose drive-enable bit is 0 has `pin_oe` = 0, and its stored level still appears on `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | External pin levels (asynchronous) |
| pin_out | output | 32 | Level driven on each pin |
| pin_oe | output | 32 | Output enable for each pin |
| alt_out | input | 32 | Alternate peripheral output levels |
| alt_oe | input | 32 | Alternate peripheral output enables |

## Verification
Directed sequences first set one group at a time to controller ownership. They show that the other groups still follow the peripheral inputs, which tells a wrong group decode apart from a wrong bit decode. Level writes made before and after the drive-enable write tell whether stored levels are held or lost. A pin step followed on two consecutive edges exposes a synchronizer that is one stage too short or too long. A driven pin whose external input disagrees with it shows which source the level readback takes. Writes with junk in the upper bytes, and writes to unaligned or out-of-range addresses, show whether state leaks through ignored fields. A long random phase of mixed writes, addresses and pin activity is compared on every cycle against a behavioural model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Register bank selected by a bus address
    typedef enum logic [1:0] {
        BANK_LEVEL = 2'd0,
        BANK_DRIVE = 2'd1,
        BANK_OWNER = 2'd2,
        BANK_NONE  = 2'd3
    } bank_e;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned NUM_BANKS  = 3;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_GRP = 4,
    localparam int unsigned GRP_IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output bank_e                bank,
    output logic [GRP_IDX_W-1:0] grp
);

    localparam int unsigned OFS_W = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] word_idx;
    logic [ADDR_W-1:0] bank_idx;
    logic [ADDR_W-1:0] grp_idx;

    always_comb begin
        word_idx = addr >> OFS_W;
        bank_idx = word_idx / ADDR_W'(NUM_GRP);
        grp_idx  = word_idx % ADDR_W'(NUM_GRP);
        grp      = grp_idx[GRP_IDX_W-1:0];
        bank     = BANK_NONE;
        if (addr[OFS_W-1:0] == '0) begin
            case (bank_idx)
                ADDR_W'(0): bank = BANK_LEVEL;
                ADDR_W'(1): bank = BANK_DRIVE;
                ADDR_W'(2): bank = BANK_OWNER;
                default:    bank = BANK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned GRP_W    = 8,
    localparam int unsigned NUM_GRP   = NUM_PINS / GRP_W,
    localparam int unsigned GRP_IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  bank_e                bank,
    input  logic [GRP_IDX_W-1:0] grp,
    input  logic [GRP_W-1:0]     wbyte,
    output logic [NUM_PINS-1:0]  level_o,
    output logic [NUM_PINS-1:0]  drive_o,
    output logic [NUM_PINS-1:0]  owner_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] level;
        logic [NUM_PINS-1:0] drive;
        logic [NUM_PINS-1:0] owner;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int g = 0; g < int'(NUM_GRP); g++) begin
                if (grp == GRP_IDX_W'(g)) begin
                    case (bank)
                        BANK_LEVEL: st_d.level[g*GRP_W +: GRP_W] = wbyte;
                        BANK_DRIVE: st_d.drive[g*GRP_W +: GRP_W] = wbyte;
                        BANK_OWNER: st_d.owner[g*GRP_W +: GRP_W] = wbyte;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= '0;
            st_q.drive <= '0;
            st_q.owner <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign drive_o = st_q.drive;
    assign owner_o = st_q.owner;

endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_state_t;

    sync_state_t sy_d, sy_q;

    always_comb begin
        sy_d.stage1 = async_i;
        sy_d.stage2 = sy_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign sync_o = sy_q.stage2;

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] level,
    input  logic [NUM_PINS-1:0] drive,
    input  logic [NUM_PINS-1:0] owner,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] alt_out,
    input  logic [NUM_PINS-1:0] alt_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] rd_level
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_comb begin
            if (owner[i]) begin
                pin_out[i] = alt_out[i];
                pin_oe[i]  = alt_oe[i];
            end else begin
                pin_out[i] = level[i];
                pin_oe[i]  = drive[i];
            end
            rd_level[i] = drive[i] ? level[i] : pin_sync[i];
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned GRP_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic [NUM_PINS-1:0] alt_out,
    input  logic [NUM_PINS-1:0] alt_oe
);

    localparam int unsigned NUM_GRP   = NUM_PINS / GRP_W;
    localparam int unsigned GRP_IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    bank_e                bank_sel;
    logic [GRP_IDX_W-1:0] grp_sel;
    logic [NUM_PINS-1:0]  level_bits;
    logic [NUM_PINS-1:0]  drive_bits;
    logic [NUM_PINS-1:0]  owner_bits;
    logic [NUM_PINS-1:0]  sync_bits;
    logic [NUM_PINS-1:0]  rd_level;
    logic [GRP_W-1:0]     rd_byte;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:GRP_W];

    gpio_addr_dec #(
        .ADDR_W  (ADDR_W),
        .NUM_GRP (NUM_GRP)
    ) u_dec (
        .addr (bus_addr),
        .bank (bank_sel),
        .grp  (grp_sel)
    );

    gpio_regbank #(
        .NUM_PINS (NUM_PINS),
        .GRP_W    (GRP_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .bank    (bank_sel),
        .grp     (grp_sel),
        .wbyte   (bus_wdata[GRP_W-1:0]),
        .level_o (level_bits),
        .drive_o (drive_bits),
        .owner_o (owner_bits)
    );

    gpio_sync2 #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_bits)
    );

    gpio_pinmux #(
        .NUM_PINS (NUM_PINS)
    ) u_mux (
        .level    (level_bits),
        .drive    (drive_bits),
        .owner    (owner_bits),
        .pin_sync (sync_bits),
        .alt_out  (alt_out),
        .alt_oe   (alt_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .rd_level (rd_level)
    );

    always_comb begin
        case (bank_sel)
            BANK_LEVEL: rd_byte = rd_level[grp_sel*GRP_W +: GRP_W];
            BANK_DRIVE: rd_byte = drive_bits[grp_sel*GRP_W +: GRP_W];
            BANK_OWNER: rd_byte = owner_bits[grp_sel*GRP_W +: GRP_W];
            default:    rd_byte = '0;
        endcase
        bus_rdata = {{(DATA_W-GRP_W){1'b0}}, rd_byte};
    end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned GRP_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] alt_out,
    input logic [NUM_PINS-1:0] alt_oe,
    input logic [NUM_PINS-1:0] level_bits,
    input logic [NUM_PINS-1:0] drive_bits,
    input logic [NUM_PINS-1:0] owner_bits,
    input logic [NUM_PINS-1:0] sync_bits
);

    localparam int unsigned NUM_GRP  = NUM_PINS / GRP_W;
    localparam int unsigned SPAN     = NUM_GRP * 4;
    localparam int unsigned MAP_END  = 3 * SPAN;

    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (owner_bits == '1 && drive_bits == '0 && level_bits == '0));

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:GRP_W] == '0);

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00 || bus_addr >= ADDR_W'(MAP_END)) |-> bus_rdata == '0);

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr[1:0] != 2'b00 || bus_addr >= ADDR_W'(MAP_END)))
        |=> ($stable(level_bits) && $stable(drive_bits) && $stable(owner_bits)));

    // R4
    periph_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_oe ^ alt_oe) | (pin_out ^ alt_out)) & owner_bits) == '0);

    // R3
    gpio_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_oe ^ drive_bits) | (pin_out ^ level_bits)) & ~owner_bits) == '0);

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr >= ADDR_W'(SPAN) && bus_addr < ADDR_W'(2*SPAN))
        |=> $stable(level_bits));

    // R6
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> sync_bits == $past(pin_in, 2));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_PINS (NUM_PINS),
    .GRP_W    (GRP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .alt_out    (alt_out),
    .alt_oe     (alt_oe),
    .level_bits (level_bits),
    .drive_bits (drive_bits),
    .owner_bits (owner_bits),
    .sync_bits  (sync_bits)
);

// File: tb/gpio_port_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [31:0] alt_out = '0;
    logic [31:0] alt_oe = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .alt_out   (alt_out),
        .alt_oe    (alt_oe)
    );

    // Behavioural reference model
    logic [31:0] m_level, m_drive, m_owner, m_s1, m_s2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_level <= 32'h0;
            m_drive <= 32'h0;
            m_owner <= 32'hFFFF_FFFF;
            m_s1    <= 32'h0;
            m_s2    <= 32'h0;
        end else begin
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            if (bus_we && bus_addr[1:0] == 2'b00 && bus_addr < 8'h30) begin
                int g;
                g = (int'(bus_addr) / 4) % 4;
                case (int'(bus_addr) / 16)
                    0: m_level[g*8 +: 8] <= bus_wdata[7:0];
                    1: m_drive[g*8 +: 8] <= bus_wdata[7:0];
                    default: m_owner[g*8 +: 8] <= bus_wdata[7:0];
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] r;
        int g;
        r = 32'h0;
        if (a[1:0] == 2'b00 && a < 8'h30) begin
            g = (int'(a) / 4) % 4;
            for (int k = 0; k < 8; k++) begin
                int p;
                p = g * 8 + k;
                case (int'(a) / 16)
                    0: r[k] = m_drive[p] ? m_level[p] : m_s2[p];
                    1: r[k] = m_drive[p];
                    default: r[k] = m_owner[p];
                endcase
            end
        end
        return r;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            logic [31:0] exp_out, exp_oe;
            string rtag;
            for (int i = 0; i < 32; i++) begin
                exp_out[i] = m_owner[i] ? alt_out[i] : m_level[i];
                exp_oe[i]  = m_owner[i] ? alt_oe[i]  : m_drive[i];
            end
            check("R4", "periph pin_oe", pin_oe & m_owner, exp_oe & m_owner);
            check("R4", "periph pin_out", pin_out & m_owner, exp_out & m_owner);
            check("R3", "gpio pin_oe", pin_oe & ~m_owner, exp_oe & ~m_owner);
            check("R3", "gpio pin_out", pin_out & ~m_owner, exp_out & ~m_owner);
            if (bus_addr[1:0] != 2'b00 || bus_addr >= 8'h30) rtag = "R8";
            else if (bus_addr < 8'h10) rtag = "R6";
            else rtag = "R2";
            check(rtag, "model rdata", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        @(posedge clk);
        #2;
        check(tag, "read", bus_rdata, exp);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1", 8'h20, 32'h0000_00FF);
        rd_chk("R1", 8'h2C, 32'h0000_00FF);
        rd_chk("R1", 8'h10, 32'h0);
        rd_chk("R1", 8'h00, 32'h0);
        @(negedge clk);
        alt_oe  = 32'hA5A5_5A5A;
        alt_out = 32'h0F0F_F0F0;
        @(posedge clk); #2;
        check("R1", "pin_oe", pin_oe, alt_oe);
        check("R1", "pin_out", pin_out, alt_out);

        // R2: group 3 taken by the controller, other groups untouched
        wr(8'h2C, 32'h0);
        wr(8'h0C, 32'h81);
        wr(8'h1C, 32'hFF);
        @(posedge clk); #2;
        check("R2", "pin_oe", pin_oe, {8'hFF, alt_oe[23:0]});
        check("R2", "pin_out", pin_out, {8'h81, alt_out[23:0]});
        rd_chk("R2", 8'h1C, 32'hFF);
        rd_chk("R2", 8'h2C, 32'h0);

        // R9 and R5: level written while input, then drive enabled
        wr(8'h24, 32'h0);
        wr(8'h04, 32'h02);
        @(posedge clk); #2;
        check("R9", "input pin_oe", {24'h0, pin_oe[15:8]}, 32'h0);
        check("R9", "input pin_out", {24'h0, pin_out[15:8]}, 32'h02);
        wr(8'h14, 32'h02);
        check("R5", "pin_oe after drive", {24'h0, pin_oe[15:8]}, 32'h02);
        check("R5", "pin_out after drive", {24'h0, pin_out[15:8]}, 32'h02);

        // R7: junk in upper write bytes
        wr(8'h04, 32'hABCD_EF02);
        rd_chk("R7", 8'h04, 32'h0000_0002);
        wr(8'h14, 32'hFFFF_FF02);
        rd_chk("R7", 8'h14, 32'h0000_0002);

        // R8: unmapped and unaligned writes have no effect
        wr(8'h30, 32'h0);
        wr(8'h21, 32'h0);
        wr(8'h12, 32'hFF);
        rd_chk("R8", 8'h20, 32'h0000_00FF);
        rd_chk("R8", 8'h10, 32'h0);
        rd_chk("R8", 8'h31, 32'h0);
        rd_chk("R8", 8'h3C, 32'h0);
        rd_chk("R8", 8'h21, 32'h0);

        // R6: synchronizer latency on pin 16
        wr(8'h28, 32'h0);
        @(negedge clk);
        pin_in   = 32'h0001_0000;
        bus_addr = 8'h08;
        @(posedge clk); #2;
        check("R6", "one edge after step", bus_rdata, 32'h0);
        @(posedge clk); #2;
        check("R6", "two edges after step", bus_rdata, 32'h1);
        // R6: output pin reads its stored level, not the input
        wr(8'h18, 32'h01);
        rd_chk("R6", 8'h08, 32'h0);

        // R4: peripheral keeps group 0 despite controller bits
        wr(8'h10, 32'hFF);
        wr(8'h00, 32'hFF);
        @(negedge clk);
        alt_oe  = 32'h0;
        alt_out = 32'h0;
        @(posedge clk); #2;
        check("R4", "periph pin_oe", {24'h0, pin_oe[7:0]}, 32'h0);
        check("R4", "periph pin_out", {24'h0, pin_out[7:0]}, 32'h0);

        // Random phase, checked by the model every cycle
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            bus_addr  = 8'($urandom_range(0, 63));
            bus_we    = ($urandom_range(0, 2) == 0);
            bus_wdata = $urandom;
            if ($urandom_range(0, 3) == 0) pin_in = $urandom;
            if ($urandom_range(0, 4) == 0) begin
                alt_out = $urandom;
                alt_oe  = $urandom;
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        summary();
    end

endmodule